// File: doc/BRIEF.md
# Double-to-int32 wrapping truncation converter

This block takes a 64-bit IEEE-754 double-precision value and produces a 32-bit signed integer. The conversion follows JavaScript integer semantics. Any fractional part is dropped, so rounding is always toward zero. If the truncated integer does not fit in 32 signed bits, the result keeps the low 32 bits of its two's-complement form rather than saturating.

Alongside the integer, the block reports:
- a four-bit condition-flag vector whose only live bit says whether the conversion was exact and in range;
- an invalid status bit;
- an inexact status bit.

Whether a raised status bit becomes a trap is decided outside the block.

An operand is offered with a valid strobe. Exactly one clock later the result and all flags appear together with a registered valid. A synchronous reset clears every output register.

Top module: `dbl_to_i32_wrap`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` was high (and reset was low), and low after cycles with `in_valid` low; result and flags are registered together with it.
- R2: For a finite input whose truncated value lies in [-2^31, 2^31-1], `out_result` is that value truncated toward zero (for example, 3.14 gives 3 and -2147483648.5 gives -2147483648), with `out_invalid` low.
- R3: For a finite input whose truncated magnitude exceeds the signed 32-bit range, `out_result` is the true integer reduced modulo 2^32 and read as signed, and `out_invalid` is high.
- R4: A negative input is converted by truncating its magnitude, taking the two's complement and keeping the low 32 bits (-1.5 gives 0xFFFFFFFF, -(2^32+5) gives 0xFFFFFFFB).
- R5: NaN and ±infinity (exponent field bits 62:52 all ones) give `out_result` = 0, `out_invalid` = 1, `out_inexact` = 0 and Z = 0.
- R6: ±0 and subnormals (exponent field zero) give 0 with `out_invalid` = 0. A nonzero subnormal sets `out_inexact`. +0 gives Z = 1 and -0 gives Z = 0.
- R7: When the unbiased exponent is 84 or more (exponent field ≥ 1107, not all ones), `out_result` is 0 and `out_invalid` is 1.
- R8: `out_nzcv` is ordered {N, Z, C, V} (bit 3 = N, bit 2 = Z). N, C and V are always 0. Z is 1 only for a finite input with no fractional part whose value lies in the signed 32-bit range, excluding -0.
- R9: `out_inexact` is 1 exactly when nonzero fraction bits are discarded by the truncation, including finite inputs with magnitude below 1.
- R10: While `rst` is high at a clock edge, every output is cleared to 0 after that edge, and an operand offered in that cycle produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 64 | Double-precision operand |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | 32 | Wrapped, truncated signed integer |
| out_nzcv | output | 4 | Condition flags {N, Z, C, V} |
| out_invalid | output | 1 | Invalid-operation status |
| out_inexact | output | 1 | Inexact status |

## Verification
The operand patterns are chosen so that each one isolates a single part of the conversion:
- Small integers and fractions of both signs separate plain truncation from fraction detection and from negation.
- The values 2^31-1, -2^31 and ±2^31 with a half added sit on both sides of the range edge. They show whether the asymmetric signed bound is applied per sign, and whether exactness and range are judged independently.
- Values just above 2^32, 2^83+2^31 and 2^84 exercise left-shifting of the significand, modular wrapping of the kept bits, and the point where every integer bit leaves the 32-bit window.
- Zeros, a subnormal, infinity and NaN confirm the special-value routing, including the sign-dependent Z of zero.

Operands are streamed back to back and also with idle gaps, and one is offered under reset, to check the valid pairing.

// File: rtl/dbl_to_i32_wrap.sv
module dbl_to_i32_wrap #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [EXP_W+FRAC_W:0]     in_data,
  output logic                      out_valid,
  output logic [INT_W-1:0]          out_result,
  output logic [3:0]                out_nzcv,
  output logic                      out_invalid,
  output logic                      out_inexact
);

  localparam int W       = EXP_W + FRAC_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int WIDE_W  = SIG_W + INT_W;
  localparam int SH_W    = $clog2(WIDE_W);
  localparam logic [EXP_W-1:0] EXP_ONE    = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_PIVOT  = EXP_W'(BIAS + FRAC_W);
  localparam logic [EXP_W-1:0] EXP_GONE   = EXP_W'(BIAS + FRAC_W + INT_W);
  localparam logic [EXP_W-1:0] EXP_EDGE   = EXP_W'(BIAS + INT_W - 1);
  localparam logic [EXP_W-1:0] EXP_WIDE   = EXP_W'(BIAS + INT_W);
  localparam int EDGE_DROP = FRAC_W - (INT_W - 1);

  logic               sgn;
  logic [EXP_W-1:0]   ex;
  logic [FRAC_W-1:0]  fr;
  logic [WIDE_W-1:0]  sig;
  logic [WIDE_W-1:0]  moved;
  logic [SH_W-1:0]    amt;
  logic [INT_W-1:0]   mag_lo;
  logic               special;
  logic               frac_nz;
  logic               too_big;
  logic               exact;

  assign sgn     = in_data[W-1];
  assign ex      = in_data[W-2:FRAC_W];
  assign fr      = in_data[FRAC_W-1:0];
  assign sig     = {{INT_W{1'b0}}, 1'b1, fr};
  assign special = &ex;

  always_comb begin
    moved   = '0;
    amt     = '0;
    frac_nz = 1'b0;
    if (special) begin
      frac_nz = 1'b0;
    end else if (ex == '0) begin
      frac_nz = |fr;
    end else if (ex < EXP_ONE) begin
      frac_nz = 1'b1;
    end else if (ex <= EXP_PIVOT) begin
      amt     = SH_W'(EXP_PIVOT - ex);
      moved   = sig >> amt;
      frac_nz = |(sig & ((WIDE_W'(1) << amt) - WIDE_W'(1)));
    end else if (ex < EXP_GONE) begin
      amt     = SH_W'(ex - EXP_PIVOT);
      moved   = sig << amt;
    end
  end

  assign mag_lo  = moved[INT_W-1:0];

  always_comb begin
    too_big = 1'b0;
    if (!special) begin
      if (ex >= EXP_WIDE && ex != '1)
        too_big = 1'b1;
      else if (ex == EXP_EDGE)
        too_big = !(sgn && fr[FRAC_W-1:EDGE_DROP] == '0);
    end
  end

  assign exact = !special && !too_big && !frac_nz && !(sgn && ex == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_nzcv    <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= sgn ? (~mag_lo + INT_W'(1)) : mag_lo;
        out_nzcv    <= {1'b0, exact, 2'b00};
        out_invalid <= special || too_big;
        out_inexact <= frac_nz;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid))); // R1

  AST_SPECIAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[W-2:FRAC_W] == '1) |=>
      (out_result == '0 && out_invalid && !out_inexact && !out_nzcv[2])); // R5

  AST_TINY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[W-2:FRAC_W] == '0) |=>
      (out_result == '0 && !out_invalid)); // R6

  AST_HUGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[W-2:FRAC_W] >= EXP_GONE && in_data[W-2:FRAC_W] != '1) |=>
      (out_result == '0 && out_invalid)); // R7

  AST_FLAGS_SHAPE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!out_nzcv[3] && out_nzcv[1:0] == 2'b00)); // R8

  AST_EXACT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_nzcv[2]) |-> (!out_invalid && !out_inexact)); // R8

  AST_SMALL_INEXACT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data[W-2:FRAC_W] != '0 && in_data[W-2:FRAC_W] < EXP_ONE) |=>
      (out_inexact && out_result == '0)); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0 && out_nzcv == '0 &&
             !out_invalid && !out_inexact)); // R10

endmodule

// File: tb/tb_dbl_to_i32_wrap.sv
`timescale 1ns/1ps
module tb_dbl_to_i32_wrap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic [3:0]  out_nzcv;
  logic        out_invalid;
  logic        out_inexact;

  int checks = 0;
  int errors = 0;
  logic [34:0] q_exp[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  dbl_to_i32_wrap dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_result(out_result), .out_nzcv(out_nzcv),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  task automatic drive(input logic [63:0] d, input logic [31:0] r,
                       input logic z, input logic inv, input logic inx,
                       input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    q_exp.push_back({r, z, inv, inx});
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (q_exp.size() == 0) begin
        errors++;
        $display("FAIL R1: unexpected out_valid, result %h expected none", out_result);
      end else begin
        logic [34:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (out_result !== e[34:3] || out_nzcv !== {1'b0, e[2], 2'b00} ||
            out_invalid !== e[1] || out_inexact !== e[0]) begin
          errors++;
          $display("FAIL %s: got res=%h nzcv=%b inv=%b inx=%b expected res=%h nzcv=%b inv=%b inx=%b",
                   t, out_result, out_nzcv, out_invalid, out_inexact,
                   e[34:3], {1'b0, e[2], 2'b00}, e[1], e[0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_result !== 32'h0 || out_nzcv !== 4'h0) begin
      errors++;
      $display("FAIL R10: reset state valid=%b res=%h nzcv=%b expected 0/0/0",
               out_valid, out_result, out_nzcv);
    end
    @(negedge clk);
    rst = 1'b0;

    drive(64'h3FF0000000000000, 32'h00000001, 1, 0, 0, "R2 one");
    drive(64'h3FF8000000000000, 32'h00000001, 0, 0, 1, "R9 one-and-half");
    drive(64'hBFF8000000000000, 32'hFFFFFFFF, 0, 0, 1, "R4 minus-one-and-half");
    drive(64'hC000000000000000, 32'hFFFFFFFE, 1, 0, 0, "R4 minus-two");
    drive(64'h3FE0000000000000, 32'h00000000, 0, 0, 1, "R9 half");
    drive(64'h40091EB851EB851F, 32'h00000003, 0, 0, 1, "R2 three-point-one-four");
    idle();
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: out_valid after idle cycle got %b expected 0", out_valid);
    end
    drive(64'h0000000000000000, 32'h00000000, 1, 0, 0, "R6 plus-zero");
    drive(64'h8000000000000000, 32'h00000000, 0, 0, 0, "R6 minus-zero");
    drive(64'h0000000000000001, 32'h00000000, 0, 0, 1, "R6 subnormal");
    drive(64'h7FF0000000000000, 32'h00000000, 0, 1, 0, "R5 infinity");
    drive(64'h7FF8000000000000, 32'h00000000, 0, 1, 0, "R5 nan");
    drive(64'h41DFFFFFFFC00000, 32'h7FFFFFFF, 1, 0, 0, "R8 int-max");
    drive(64'hC1E0000000000000, 32'h80000000, 1, 0, 0, "R8 int-min");
    drive(64'h41E0000000000000, 32'h80000000, 0, 1, 0, "R3 two-pow-31");
    drive(64'hC1E0000000100000, 32'h80000000, 0, 0, 1, "R2 int-min-minus-half");
    drive(64'h41E0000000100000, 32'h80000000, 0, 1, 1, "R3 two-pow-31-plus-half");
    drive(64'h41F0000000500000, 32'h00000005, 0, 1, 0, "R3 two-pow-32-plus-5");
    drive(64'hC1F0000000500000, 32'hFFFFFFFB, 0, 1, 0, "R4 neg-two-pow-32-plus-5");
    drive(64'h4520000000000001, 32'h80000000, 0, 1, 0, "R7 two-pow-83-plus-31");
    drive(64'h4530000000000000, 32'h00000000, 0, 1, 0, "R7 two-pow-84");
    idle();
    idle();

    @(negedge clk);
    rst      = 1'b1;
    in_valid = 1'b1;
    in_data  = 64'h3FF0000000000000;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b0 || out_result !== 32'h0 || out_nzcv !== 4'h0 ||
        out_invalid !== 1'b0 || out_inexact !== 1'b0) begin
      errors++;
      $display("FAIL R10: under reset got valid=%b res=%h expected 0/0",
               out_valid, out_result);
    end
    rst = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (q_exp.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d results missing expected 0", q_exp.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule